// File: doc/BRIEF.md
# Weighted Priority Grant-Count Arbiter

This block shares one downstream fetch port among three requesters: A (lowest priority), B (middle) and C (highest priority). Each requester owns a 4-bit budget field in a single 32-bit control register. The arbiter always grants the highest-priority requester that is requesting and still has budget left. A lower-priority requester therefore keeps the port only until a higher-priority requester with budget appears. It also loses the port once its own budget runs out.

Each requester has a working counter. The counter drops by one for every grant the port accepts. When no requester with budget left is requesting, every working counter reloads from the register in the following cycle, so a new budget period starts. The register can be written until a lock is applied. The lock stays in place until reset.

Top module: `wgc_arbiter`

## Requirements
- R1: After reset the readback is 0x0000FFFF and every working counter holds 15, so a requester is eligible at once.
- R2: The readback places the C budget in bits 11:8, the B budget in bits 7:4 and the A budget in bits 3:0. Bits 15:12 always read 0xF and bits 31:16 always read zero. Writes to the reserved bits have no effect.
- R3: The grant is one-hot or all-zero, with bit 2 for C, bit 1 for B and bit 0 for A. It is all-zero when no requester is eligible, and a grant bit is set only while its request is high.
- R4: Among the requesters that are requesting with a nonzero working count, the highest-priority one is granted in the same cycle.
- R5: A cycle in which the accept strobe is high while a grant bit is set lowers that requester's working count by one. With unchanged requests, a requester is therefore granted exactly as many accepted cycles as its budget.
- R6: In a cycle with no eligible requester, the grant is zero and all working counters load from the register at the next clock edge.
- R7: With all three requesting and accept held high, the grant order is all of C's budget, then B's, then A's, then one empty reload cycle, then C again.
- R8: A requester programmed with a budget of zero is never granted.
- R9: A register write changes the working counters only at the next reload. It does not alter the budget of the period in progress.
- R10: Once the lock input has been high, later writes are ignored until reset. Reset clears the lock.
- R11: Without accept, the working counters hold, so the same requester keeps the grant while requests are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Request lines: bit 2 C, bit 1 B, bit 0 A |
| accept_i | input | 1 | Downstream port took the granted fetch this cycle |
| cfg_wr_en_i | input | 1 | Register write strobe |
| cfg_wr_data_i | input | 32 | Register write data |
| cfg_lock_i | input | 1 | Lock request; sticky until reset |
| gnt_o | output | 3 | One-hot grant, same bit order as req_i |
| cfg_rd_data_o | output | 32 | Register readback |

## Verification
The bench first drives single requesters and requester pairs without accept. This separates pure priority selection from budget consumption and shows that the grant holds. It then drives all three requesters with accept held high and uneven budgets. The resulting grant order exposes off-by-one errors in the counting and in the placement of the reload cycle. A zero budget on the middle requester tests skipping, and a write issued in the middle of a period shows whether the new budget is picked up early. Lock patterns compare the readback before and after writes, and again across a reset.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
    localparam int NREQ_DEF  = 3;
    localparam int CNT_W_DEF = 4;
    localparam int REG_W_DEF = 32;
    localparam int VIS_W     = 16;

    typedef enum int unsigned {
        SLOT_A = 0,
        SLOT_B = 1,
        SLOT_C = 2
    } slot_e;
endpackage

// File: rtl/wgc_cfg_reg.sv
module wgc_cfg_reg #(
    parameter int NUM_REQ = wgc_pkg::NREQ_DEF,
    parameter int CNT_W   = wgc_pkg::CNT_W_DEF,
    parameter int REG_W   = wgc_pkg::REG_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [REG_W-1:0]           wr_data_i,
    input  logic                       lock_i,
    output logic [NUM_REQ*CNT_W-1:0]   fields_o,
    output logic [REG_W-1:0]           rd_data_o
);
    localparam int FW = NUM_REQ * CNT_W;

    typedef struct packed {
        logic [FW-1:0] fields;
        logic          locked;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       wr_unused;

    assign wr_unused = ^wr_data_i[REG_W-1:FW];

    always_comb begin
        st_d = st_q;
        if (lock_i) begin
            st_d.locked = 1'b1;
        end
        if (wr_en_i && !st_q.locked && !lock_i) begin
            st_d.fields = wr_data_i[FW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fields <= '1;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int b = FW; b < wgc_pkg::VIS_W; b++) begin
            rd_data_o[b] = 1'b1;
        end
        rd_data_o[FW-1:0] = st_q.fields;
    end

    assign fields_o = st_q.fields;
endmodule

// File: rtl/wgc_budget.sv
module wgc_budget #(
    parameter int CNT_W = wgc_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             nz_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bud_state_t;

    bud_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = init_i;
        end else if (dec_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign nz_o  = |st_q.cnt;
endmodule

// File: rtl/wgc_prio_pick.sv
module wgc_prio_pick #(
    parameter int N = wgc_pkg::NREQ_DEF
) (
    input  logic [N-1:0] elig_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wgc_arbiter.sv
module wgc_arbiter #(
    parameter int NUM_REQ = wgc_pkg::NREQ_DEF,
    parameter int CNT_W   = wgc_pkg::CNT_W_DEF,
    parameter int REG_W   = wgc_pkg::REG_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               accept_i,
    input  logic               cfg_wr_en_i,
    input  logic [REG_W-1:0]   cfg_wr_data_i,
    input  logic               cfg_lock_i,
    output logic [NUM_REQ-1:0] gnt_o,
    output logic [REG_W-1:0]   cfg_rd_data_o
);
    localparam int FW = NUM_REQ * CNT_W;

    logic [FW-1:0]      fields;
    logic [FW-1:0]      wcnt_flat;
    logic [NUM_REQ-1:0] nz;
    logic [NUM_REQ-1:0] elig;
    logic [NUM_REQ-1:0] gnt;
    logic               reload;

    wgc_cfg_reg #(
        .NUM_REQ (NUM_REQ),
        .CNT_W   (CNT_W),
        .REG_W   (REG_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en_i),
        .wr_data_i (cfg_wr_data_i),
        .lock_i    (cfg_lock_i),
        .fields_o  (fields),
        .rd_data_o (cfg_rd_data_o)
    );

    assign elig   = req_i & nz;
    assign reload = ~|elig;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_budget
        wgc_budget #(
            .CNT_W (CNT_W)
        ) bud_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (reload),
            .dec_i  (gnt[g] & accept_i),
            .init_i (fields[g*CNT_W +: CNT_W]),
            .cnt_o  (wcnt_flat[g*CNT_W +: CNT_W]),
            .nz_o   (nz[g])
        );
    end

    wgc_prio_pick #(
        .N (NUM_REQ)
    ) pick_i (
        .elig_i (elig),
        .gnt_o  (gnt)
    );

    assign gnt_o = gnt;
endmodule

// File: rtl/wgc_arbiter_chk.sv
module wgc_arbiter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  req_i,
    input logic        accept_i,
    input logic        wr_en_i,
    input logic        lock_i,
    input logic [2:0]  gnt_i,
    input logic [31:0] rd_i,
    input logic [11:0] wcnt_i,
    input logic [11:0] fields_i
);
    logic [2:0] live;
    logic       lock_seen;

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            live[i] = req_i[i] && (wcnt_i[i*4 +: 4] != 4'd0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_seen <= 1'b0;
        else        lock_seen <= lock_seen | lock_i;
    end

    // R2
    rsv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i[31:12] == 20'h0000F);

    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_i));

    // R3
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i & ~req_i) == 3'b000);

    // R4
    prio_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_i[wgc_pkg::SLOT_A] |-> !(live[wgc_pkg::SLOT_B] || live[wgc_pkg::SLOT_C]));

    // R4
    prio_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_i[wgc_pkg::SLOT_B] |-> !live[wgc_pkg::SLOT_C]);

    // R4
    work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|live) |-> (|gnt_i));

    // R8
    no_empty_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i & ~live) == 3'b000);

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 3'b000) |=> (wcnt_i == $past(fields_i)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && (|gnt_i)) |=> $stable(wcnt_i));

    // R10
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_seen || lock_i) && wr_en_i) |=> $stable(rd_i));

    for (genvar i = 0; i < 3; i++) begin : g_dec
        // R5
        dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_i[i] && accept_i) |=> (wcnt_i[i*4 +: 4] == $past(wcnt_i[i*4 +: 4]) - 4'd1));
    end
endmodule

bind wgc_arbiter wgc_arbiter_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .accept_i (accept_i),
    .wr_en_i  (cfg_wr_en_i),
    .lock_i   (cfg_lock_i),
    .gnt_i    (gnt_o),
    .rd_i     (cfg_rd_data_o),
    .wcnt_i   (wcnt_flat),
    .fields_i (fields)
);

// File: tb/wgc_arbiter_tb_top.sv
module wgc_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req = '0;
    logic        accept = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        lock = 1'b0;
    logic [2:0]  gnt;
    logic [31:0] rd;

    logic        p_we = 1'b0;
    logic [31:0] p_wd = '0;
    logic        p_lock = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wgc_arbiter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .accept_i      (accept),
        .cfg_wr_en_i   (wr_en),
        .cfg_wr_data_i (wr_data),
        .cfg_lock_i    (lock),
        .gnt_o         (gnt),
        .cfg_rd_data_o (rd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] r, input logic a, output logic [2:0] g);
        @(negedge clk);
        req     = r;
        accept  = a;
        wr_en   = p_we;
        wr_data = p_wd;
        lock    = p_lock;
        p_we    = 1'b0;
        p_lock  = 1'b0;
        #1 g = gnt;
    endtask

    task automatic idle();
        logic [2:0] g;
        step(3'b000, 1'b0, g);
        step(3'b000, 1'b0, g);
    endtask

    task automatic cfg_write(input logic [31:0] d);
        logic [2:0] g;
        p_we = 1'b1;
        p_wd = d;
        step(3'b000, 1'b0, g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0; accept = 1'b0; wr_en = 1'b0; lock = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic run_seq(input string tag, input logic [2:0] r, input logic a,
                           input logic [2:0] exp [8], input int n);
        logic [2:0] g;
        for (int i = 0; i < n; i++) begin
            step(r, a, g);
            check($sformatf("%s cycle %0d", tag, i), {29'd0, g}, {29'd0, exp[i]});
        end
    endtask

    // R1 R3 R4: reset state and plain priority
    task automatic t_reset();
        logic [2:0] g;
        do_reset();
        check("R1 reset readback", rd, 32'h0000FFFF);
        step(3'b111, 1'b0, g); check("R1 R4 all requesting", {29'd0, g}, 32'd4);
        step(3'b011, 1'b0, g); check("R4 B over A", {29'd0, g}, 32'd2);
        step(3'b001, 1'b0, g); check("R4 A alone", {29'd0, g}, 32'd1);
        step(3'b000, 1'b0, g); check("R3 no request", {29'd0, g}, 32'd0);
    endtask

    // R2: field layout and reserved bits
    task automatic t_layout();
        cfg_write(32'hFFFF_0321);
        idle();
        check("R2 readback layout", rd, 32'h0000F321);
    endtask

    // R5 R6 R7: full contention with uneven budgets
    task automatic t_rotation();
        logic [2:0] e [8];
        cfg_write(32'h0000F231);
        idle();
        e = '{3'b100, 3'b100, 3'b010, 3'b010, 3'b010, 3'b001, 3'b000, 3'b100};
        run_seq("R7 R5 R6 rotation", 3'b111, 1'b1, e, 8);
        idle();
    endtask

    // R4 R11: preemption and hold without accept
    task automatic t_preempt();
        logic [2:0] g;
        idle();
        step(3'b001, 1'b0, g); check("R4 A alone", {29'd0, g}, 32'd1);
        step(3'b101, 1'b0, g); check("R4 C preempts A", {29'd0, g}, 32'd4);
        for (int i = 0; i < 3; i++) begin
            step(3'b011, 1'b0, g); check("R11 B holds", {29'd0, g}, 32'd2);
        end
        for (int i = 0; i < 3; i++) begin
            step(3'b011, 1'b1, g); check("R5 B budget", {29'd0, g}, 32'd2);
        end
        step(3'b011, 1'b1, g); check("R5 A after B spent", {29'd0, g}, 32'd1);
        step(3'b011, 1'b1, g); check("R6 reload gap", {29'd0, g}, 32'd0);
        step(3'b011, 1'b1, g); check("R6 B after reload", {29'd0, g}, 32'd2);
        idle();
    endtask

    // R8: zero budget skipped
    task automatic t_zero();
        logic [2:0] e [8];
        logic [2:0] g;
        cfg_write(32'h0000F201);
        idle();
        e = '{3'b100, 3'b100, 3'b001, 3'b000, 3'b100, 3'b000, 3'b000, 3'b000};
        run_seq("R8 zero B skipped", 3'b111, 1'b1, e, 5);
        idle();
        step(3'b010, 1'b1, g); check("R8 B alone never", {29'd0, g}, 32'd0);
        step(3'b010, 1'b1, g); check("R8 B alone never", {29'd0, g}, 32'd0);
        idle();
    endtask

    // R9: write mid-period waits for reload
    task automatic t_midwrite();
        logic [2:0] g;
        cfg_write(32'h0000F311);
        idle();
        step(3'b100, 1'b1, g); check("R9 C first", {29'd0, g}, 32'd4);
        p_we = 1'b1; p_wd = 32'h0000F511;
        step(3'b100, 1'b1, g); check("R9 C second", {29'd0, g}, 32'd4);
        step(3'b100, 1'b1, g); check("R9 C third", {29'd0, g}, 32'd4);
        step(3'b100, 1'b1, g); check("R9 old budget ends", {29'd0, g}, 32'd0);
        step(3'b100, 1'b1, g); check("R9 new budget", {29'd0, g}, 32'd4);
        step(3'b100, 1'b1, g); check("R9 new budget", {29'd0, g}, 32'd4);
        idle();
        check("R9 readback", rd, 32'h0000F511);
    endtask

    // R10: lock sticky, cleared by reset
    task automatic t_lock();
        logic [2:0] g;
        p_lock = 1'b1;
        step(3'b000, 1'b0, g);
        cfg_write(32'h0000F777);
        idle();
        check("R10 write after lock ignored", rd, 32'h0000F511);
        do_reset();
        check("R10 R1 reset value", rd, 32'h0000FFFF);
        cfg_write(32'h0000F456);
        idle();
        check("R10 unlocked after reset", rd, 32'h0000F456);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_rotation();
        t_preempt();
        t_zero();
        t_midwrite();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule